// File: doc/BRIEF.md
# Vector Control/Status Register Access Unit

This block keeps the architectural state that governs vector execution: the active element count, the active type descriptor, the element index to resume from, the fixed-point rounding mode and the sticky saturation flag. It also answers reads of a constant that gives the register length in bytes. The scalar core forwards control-register access operations to it, already decoded into an operation code, a register address and a source operand.

An access is never carried out while vector work is still in flight. A request that arrives in the idle state moves the controller into a wait state, and it stays there until the backend reports idle. In the cycle the access is accepted, the unit returns the register's previous value, or it raises an illegal-access flag and changes nothing. The new value becomes visible at the next clock edge. Element count and type are never written by these accesses. A separate preload port sets them, standing in for the configuration path.

Top module: `vcsr_unit`

## Requirements
- R1: Operation code `req_op_i[1:0]` selects the update: 01 writes the operand, 10 ORs it into the old value, 11 clears the operand's set bits from the old value.
- R2: When `req_op_i[2]` is 1 (immediate forms 5, 6, 7), the operand is `req_src_i[4:0]` zero-extended; otherwise it is the full `req_src_i`.
- R3: A write-type access to element count (0xC20), type (0xC21) or length-in-bytes (0xC22) raises `illegal_o`, and the register keeps its value.
- R4: An address other than 0x008 (start index), 0x009 (saturation), 0x00A (rounding mode), 0xC20, 0xC21, 0xC22, or an operation code of 0 or 4, raises `illegal_o`, leaves all registers unchanged and returns read data 0.
- R5: A set or clear with a zero operand is a pure read. It is legal on every known address and changes nothing.
- R6: `req_ready_o` is never high in the cycle a request first arrives in the idle state. It rises in the first later cycle in which `backend_idle_i` is high, and it stays low while the backend is busy.
- R7: The rounding mode keeps only operand bits [1:0] and the saturation flag only bit 0. Reads of both return the value zero-extended to XLEN.
- R8: Reading 0xC22 returns VLEN/8.
- R9: Read data in the accepting cycle is the register's value before the access. The updated value is seen by the next access.
- R10: After reset, start index, rounding mode, saturation flag and element count read 0, and type reads with only bit XLEN-1 set (the invalid-type pattern).
- R11: A cycle with `preload_en_i` high loads element count and type from the preload inputs, and later reads return them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request; held with its fields until accepted |
| req_op_i | input | 3 | Operation code |
| req_addr_i | input | 12 | Register address |
| req_src_i | input | XLEN | Source operand or immediate in bits [4:0] |
| backend_idle_i | input | 1 | Vector backend has no work in flight |
| preload_en_i | input | 1 | Load element count and type this cycle |
| preload_vl_i | input | XLEN | Element count to preload |
| preload_vtype_i | input | XLEN | Type descriptor to preload |
| req_ready_o | output | 1 | Access accepted this cycle |
| rdata_o | output | XLEN | Previous register value; 0 when not accepted or illegal |
| illegal_o | output | 1 | Accepted access was rejected as illegal |

## Verification
The bench builds the unit with XLEN = 32 and VLEN = 256, so the length-in-bytes read must return 32. The invalid-type reset pattern lands in bit 31. A 32-bit width lets random operands set bits far above the 2-bit and 1-bit fields, which exercises truncation and zero-extension, and lets immediates with upper bits set show that only five bits are used. Random backend stalls of zero to two cycles test the idle gating on every operation code and every address.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;

    // Access operation codes; bit 2 marks the immediate-operand forms
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_RW   = 3'd1,
        OP_RS   = 3'd2,
        OP_RC   = 3'd3,
        OP_RSV  = 3'd4,
        OP_RWI  = 3'd5,
        OP_RSI  = 3'd6,
        OP_RCI  = 3'd7
    } csr_op_e;

    localparam logic [11:0] ADDR_VSTART = 12'h008;
    localparam logic [11:0] ADDR_VXSAT  = 12'h009;
    localparam logic [11:0] ADDR_VXRM   = 12'h00A;
    localparam logic [11:0] ADDR_VL     = 12'hC20;
    localparam logic [11:0] ADDR_VTYPE  = 12'hC21;
    localparam logic [11:0] ADDR_VLENB  = 12'hC22;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_VSTART,
        SEL_VXSAT,
        SEL_VXRM,
        SEL_VL,
        SEL_VTYPE,
        SEL_VLENB
    } csr_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT_IDLE
    } fsm_e;

endpackage

// File: rtl/vcsr_decode.sv
module vcsr_decode
    import vcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      op_i,
    input  logic [11:0]     addr_i,
    input  logic [XLEN-1:0] src_i,
    output csr_sel_e        sel_o,
    output logic [XLEN-1:0] operand_o,
    output logic            wr_o,
    output logic            illegal_o
);
    localparam int IMM_W = 5;

    logic op_ok;
    logic read_only;

    always_comb begin
        unique case (addr_i)
            ADDR_VSTART: sel_o = SEL_VSTART;
            ADDR_VXSAT:  sel_o = SEL_VXSAT;
            ADDR_VXRM:   sel_o = SEL_VXRM;
            ADDR_VL:     sel_o = SEL_VL;
            ADDR_VTYPE:  sel_o = SEL_VTYPE;
            ADDR_VLENB:  sel_o = SEL_VLENB;
            default:     sel_o = SEL_NONE;
        endcase

        // immediate forms carry a short unsigned value in the low source bits
        operand_o = op_i[2] ? XLEN'(src_i[IMM_W-1:0]) : src_i;
        op_ok     = (op_i[1:0] != 2'b00);
        // a set or clear with nothing to set or clear is only a read
        wr_o      = (op_i[1:0] == 2'b01) || (operand_o != '0);
        read_only = (sel_o == SEL_VL) || (sel_o == SEL_VTYPE) || (sel_o == SEL_VLENB);
        illegal_o = (sel_o == SEL_NONE) || !op_ok || (wr_o && read_only);
    end

endmodule

// File: rtl/vcsr_update.sv
module vcsr_update #(
    parameter int XLEN = 32
) (
    input  logic [1:0]      kind_i,
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] operand_i,
    output logic [XLEN-1:0] new_o
);
    always_comb begin
        unique case (kind_i)
            2'b01:   new_o = operand_i;
            2'b10:   new_o = old_i | operand_i;
            2'b11:   new_o = old_i & ~operand_i;
            default: new_o = old_i;
        endcase
    end

endmodule

// File: rtl/vcsr_unit.sv
module vcsr_unit
    import vcsr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VLEN = 256
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_valid_i,
    input  logic [2:0]      req_op_i,
    input  logic [11:0]     req_addr_i,
    input  logic [XLEN-1:0] req_src_i,
    input  logic            backend_idle_i,
    input  logic            preload_en_i,
    input  logic [XLEN-1:0] preload_vl_i,
    input  logic [XLEN-1:0] preload_vtype_i,
    output logic            req_ready_o,
    output logic [XLEN-1:0] rdata_o,
    output logic            illegal_o
);
    localparam int              VLENB       = VLEN / 8;
    localparam logic [XLEN-1:0] VTYPE_RESET = {1'b1, {(XLEN-1){1'b0}}};

    typedef struct packed {
        fsm_e            fsm;
        logic [XLEN-1:0] vstart;
        logic [1:0]      vxrm;
        logic            vxsat;
        logic [XLEN-1:0] vl;
        logic [XLEN-1:0] vtype;
    } state_t;

    state_t s_d, s_q;

    csr_sel_e        sel;
    logic [XLEN-1:0] operand;
    logic            wr;
    logic            bad;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] new_val;

    vcsr_decode #(.XLEN(XLEN)) u_decode (
        .op_i      (req_op_i),
        .addr_i    (req_addr_i),
        .src_i     (req_src_i),
        .sel_o     (sel),
        .operand_o (operand),
        .wr_o      (wr),
        .illegal_o (bad)
    );

    vcsr_update #(.XLEN(XLEN)) u_update (
        .kind_i    (req_op_i[1:0]),
        .old_i     (old_val),
        .operand_i (operand),
        .new_o     (new_val)
    );

    // previous value of the addressed register, zero-extended
    always_comb begin
        unique case (sel)
            SEL_VSTART: old_val = s_q.vstart;
            SEL_VXSAT:  old_val = XLEN'(s_q.vxsat);
            SEL_VXRM:   old_val = XLEN'(s_q.vxrm);
            SEL_VL:     old_val = s_q.vl;
            SEL_VTYPE:  old_val = s_q.vtype;
            SEL_VLENB:  old_val = XLEN'(VLENB);
            default:    old_val = '0;
        endcase
    end

    always_comb begin
        s_d         = s_q;
        req_ready_o = 1'b0;
        unique case (s_q.fsm)
            ST_IDLE: begin
                if (req_valid_i) s_d.fsm = ST_WAIT_IDLE;
            end
            ST_WAIT_IDLE: begin
                if (!req_valid_i) begin
                    s_d.fsm = ST_IDLE;
                end else if (backend_idle_i) begin
                    req_ready_o = 1'b1;
                    s_d.fsm     = ST_IDLE;
                    if (!bad && wr) begin
                        unique case (sel)
                            SEL_VSTART: s_d.vstart = new_val;
                            SEL_VXRM:   s_d.vxrm   = new_val[1:0];
                            SEL_VXSAT:  s_d.vxsat  = new_val[0];
                            default:    ;
                        endcase
                    end
                end
            end
            default: s_d.fsm = ST_IDLE;
        endcase
        if (preload_en_i) begin
            s_d.vl    = preload_vl_i;
            s_d.vtype = preload_vtype_i;
        end
    end

    assign illegal_o = req_ready_o && bad;
    assign rdata_o   = (req_ready_o && !bad) ? old_val : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.fsm    <= ST_IDLE;
            s_q.vstart <= '0;
            s_q.vxrm   <= '0;
            s_q.vxsat  <= 1'b0;
            s_q.vl     <= '0;
            s_q.vtype  <= VTYPE_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assert_illegal_keeps_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |=> ($stable(s_q.vstart) && $stable(s_q.vxrm) && $stable(s_q.vxsat)));

    assert_ro_write_rejected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_ready_o && wr && (sel == SEL_VL || sel == SEL_VTYPE || sel == SEL_VLENB)) |-> illegal_o);

    assert_accept_after_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> ($past(req_valid_i) && backend_idle_i));

    assert_rounding_zero_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_ready_o && !illegal_o && sel == SEL_VXRM) |-> (rdata_o[XLEN-1:2] == '0));

    assert_length_bytes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_ready_o && !illegal_o && sel == SEL_VLENB) |-> (rdata_o == XLEN'(VLENB)));

endmodule

// File: tb/sim_vcsr_unit.sv
module sim_vcsr_unit;
    localparam int XLEN = 32;
    localparam int VLEN = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = '0;
    logic [11:0]     req_addr = '0;
    logic [XLEN-1:0] req_src = '0;
    logic            backend_idle = 1'b1;
    logic            preload_en = 1'b0;
    logic [XLEN-1:0] preload_vl = '0;
    logic [XLEN-1:0] preload_vtype = '0;
    logic            req_ready;
    logic [XLEN-1:0] rdata;
    logic            illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference state
    logic [XLEN-1:0] m_vstart, m_vl, m_vtype;
    logic [1:0]      m_vxrm;
    logic            m_vxsat;

    always #5 clk = ~clk;

    vcsr_unit #(.XLEN(XLEN), .VLEN(VLEN)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .req_addr_i(req_addr), .req_src_i(req_src), .backend_idle_i(backend_idle),
        .preload_en_i(preload_en), .preload_vl_i(preload_vl), .preload_vtype_i(preload_vtype),
        .req_ready_o(req_ready), .rdata_o(rdata), .illegal_o(illegal)
    );

    task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit known(input logic [11:0] a);
        return a == 12'h008 || a == 12'h009 || a == 12'h00A ||
               a == 12'hC20 || a == 12'hC21 || a == 12'hC22;
    endfunction

    function automatic logic [XLEN-1:0] ref_read(input logic [11:0] a);
        case (a)
            12'h008: return m_vstart;
            12'h009: return XLEN'(m_vxsat);
            12'h00A: return XLEN'(m_vxrm);
            12'hC20: return m_vl;
            12'hC21: return m_vtype;
            12'hC22: return XLEN'(VLEN / 8);
            default: return '0;
        endcase
    endfunction

    task automatic reset_model();
        m_vstart = '0; m_vxrm = '0; m_vxsat = 1'b0; m_vl = '0;
        m_vtype = {1'b1, {(XLEN-1){1'b0}}};
    endtask

    task automatic access(input logic [2:0] op, input logic [11:0] addr,
                          input logic [XLEN-1:0] src, input int stall, input string tag);
        logic [XLEN-1:0] opnd, old, nv, exp_rd;
        bit wr, ro, ill;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_src = src;
        backend_idle = (stall == 0);
        #1;
        check(req_ready == 1'b0, "R6 ready in arrival cycle", XLEN'(req_ready), '0);
        @(posedge clk);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            backend_idle = 1'b0;
            #1;
            check(req_ready == 1'b0, "R6 ready while busy", XLEN'(req_ready), '0);
            @(posedge clk);
        end
        @(negedge clk);
        backend_idle = 1'b1;
        #1;
        opnd = op[2] ? XLEN'(src[4:0]) : src;
        wr   = (op[1:0] == 2'b01) || (opnd != '0);
        ro   = (addr == 12'hC20) || (addr == 12'hC21) || (addr == 12'hC22);
        ill  = !known(addr) || (op[1:0] == 2'b00) || (wr && ro);
        old  = ref_read(addr);
        exp_rd = ill ? '0 : old;
        check(req_ready == 1'b1, {tag, " R6 accept"}, XLEN'(req_ready), 1);
        check(illegal == ill, {tag, " R3/R4 illegal flag"}, XLEN'(illegal), XLEN'(ill));
        check(rdata == exp_rd, {tag, " R9 read data"}, rdata, exp_rd);
        if (!ill && wr) begin
            case (op[1:0])
                2'b01:   nv = opnd;
                2'b10:   nv = old | opnd;
                default: nv = old & ~opnd;
            endcase
            case (addr)
                12'h008: m_vstart = nv;
                12'h009: m_vxsat  = nv[0];
                12'h00A: m_vxrm   = nv[1:0];
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [11:0] addrs [7];
        void'($urandom(32'd20240607));
        addrs = '{12'h008, 12'h009, 12'h00A, 12'hC20, 12'hC21, 12'hC22, 12'h00F};
        reset_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(req_ready == 1'b0 && illegal == 1'b0, "R10 idle outputs after reset",
              {30'b0, req_ready, illegal}, '0);

        // R10: reset values read back through pure reads (R5)
        foreach (addrs[k]) if (k < 6) access(3'd2, addrs[k], '0, 0, "R10 reset read");
        access(3'd3, 12'hC20, '0, 1, "R5 zero clear on count");
        access(3'd6, 12'hC21, 32'hFFFF_FFE0, 0, "R5 R2 zero immediate set on type");

        // R1 basic operations on start index
        access(3'd1, 12'h008, 32'h0000_00F0, 0, "R1 write");
        access(3'd2, 12'h008, 32'h0000_000F, 0, "R1 set");
        access(3'd3, 12'h008, 32'h0000_0033, 0, "R1 clear");
        access(3'd2, 12'h008, '0, 0, "R9 readback");
        // R2 immediate forms use five bits
        access(3'd5, 12'h008, 32'hFFFF_FFE5, 0, "R2 write imm");
        access(3'd6, 12'h008, 32'h0000_0038, 0, "R2 set imm");
        access(3'd7, 12'h008, 32'h0000_0021, 0, "R2 clear imm");
        access(3'd2, 12'h008, '0, 0, "R2 readback");
        // R7 truncation and zero extension
        access(3'd1, 12'h00A, 32'hFFFF_FFFF, 0, "R7 rounding write");
        access(3'd2, 12'h00A, '0, 0, "R7 rounding read");
        access(3'd1, 12'h009, 32'h0000_0006, 0, "R7 saturation even");
        access(3'd2, 12'h009, '0, 0, "R7 saturation read");
        access(3'd5, 12'h009, 32'h0000_0007, 0, "R7 saturation imm");
        access(3'd2, 12'h009, '0, 0, "R7 saturation read2");
        // R8
        access(3'd2, 12'hC22, '0, 0, "R8 length bytes");
        // R3 write attempts on read-only registers
        access(3'd1, 12'hC20, 32'h5, 0, "R3 write count");
        access(3'd2, 12'hC21, 32'h1, 0, "R3 set type");
        access(3'd7, 12'hC22, 32'h3, 0, "R3 clear imm length");
        // R4 bad codes and address
        access(3'd0, 12'h008, 32'h7, 0, "R4 opcode 0");
        access(3'd4, 12'h00A, 32'h1, 0, "R4 opcode 4");
        access(3'd1, 12'h00F, 32'h9, 0, "R4 unknown address");
        access(3'd2, 12'h008, '0, 0, "R4 state kept");
        // R6 long stall
        access(3'd1, 12'h008, 32'h1234, 3, "R6 stall three");

        // R11 preload
        @(negedge clk);
        preload_en = 1'b1; preload_vl = 32'd17; preload_vtype = 32'h0000_00D3;
        @(negedge clk);
        preload_en = 1'b0;
        m_vl = 32'd17; m_vtype = 32'h0000_00D3;
        access(3'd2, 12'hC20, '0, 0, "R11 preloaded count");
        access(3'd3, 12'hC21, '0, 0, "R11 preloaded type");
        access(3'd1, 12'hC20, 32'd3, 0, "R3 R11 count write rejected");
        access(3'd2, 12'hC20, '0, 0, "R3 R11 count unchanged");

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [XLEN-1:0] s;
            s = ($urandom % 4 == 0) ? '0 : $urandom;
            access(3'($urandom % 8), addrs[$urandom % 7], s, int'($urandom % 3), "R1/R9 random");
        end

        // R10: reset mid-run restores reset values
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        reset_model();
        foreach (addrs[k]) if (k < 5) access(3'd6, addrs[k], '0, 0, "R10 second reset read");

        finish_run();
    end

endmodule